// File: doc/BRIEF.md
# Program Memory Boot Loader Controller

This controller fills a processor's program memory with a complete image before the processor runs. A two-bit boot mode selects the source and destination. In halt mode the processor is held in reset and nothing is written. In the two host modes an external host sends bytes into a 32-entry input FIFO. The host sends one 32-byte packet each time the FIFO reports empty, and the controller moves the bytes into program memory. One of these host modes also copies every byte to external non-volatile storage. In storage mode the image is read back from that storage through a valid/ready request port with a separate read response, and the host stream is ignored.

Program memory is written one byte at a time, from address 0 upward, with a 13-bit address by default. After the last address has been written, the controller raises its programmed flag and releases the processor's reset. If the mode input changes at any point, the current load is abandoned and loading starts over from address 0 in the new mode.

Top module: `boot_loader_ctrl`

## Requirements
- R1: With `boot_mode` = 2'b00 (halt), `cpu_rst_n` is 0 and `programmed` is 0. No program memory write and no storage request is issued. Host bytes are discarded, so `fifo_empty` stays 1.
- R2: Within one load, program memory writes use addresses 0, 1, 2 … 8191 in that order, one address per written byte. The bytes are written in the order they arrived from their source.
- R3: With `boot_mode` = 2'b01 (mirror), each program memory write happens in the same cycle as an accepted storage write request (`nv_req_write` = 1). That request carries the same address and the same byte. A byte stays in the FIFO until storage accepts it.
- R4: With `boot_mode` = 2'b10 (host only), host bytes go to program memory only, and `nv_req_valid` stays 0.
- R5: With `boot_mode` = 2'b11 (storage), the controller issues read requests (`nv_req_write` = 0) for addresses 0 to 8191 in order. It writes each `nv_rsp_data` byte to the requested address. A pending request keeps its address until accepted. Host bytes are discarded, so `fifo_empty` stays 1.
- R6: In the cycle after the write to address 8191, `programmed` and `cpu_rst_n` both become 1. From the start of a load until then, `cpu_rst_n` is 0. Once a load is complete, further host bytes are discarded.
- R7: `fifo_empty` is 1 when the FIFO holds no byte. `fifo_full` is 1 when it holds 32 bytes. A byte pushed while the FIFO is full is dropped.
- R8: When `boot_mode` changes, the next cycle shows `programmed` = 0, `cpu_rst_n` = 0 and `fifo_empty` = 1. The new load then writes from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 2 | Boot mode: 00 halt, 01 mirror, 10 host only, 11 storage |
| host_push | input | 1 | Host byte strobe |
| host_data | input | 8 | Host byte |
| fifo_empty | output | 1 | Input FIFO empty; the host may send a 32-byte packet |
| fifo_full | output | 1 | Input FIFO holds 32 bytes |
| pm_we | output | 1 | Program memory write strobe |
| pm_addr | output | 13 | Program memory byte address |
| pm_wdata | output | 8 | Program memory write byte |
| nv_req_valid | output | 1 | Storage request valid |
| nv_req_write | output | 1 | Storage request is a write (1) or a read (0) |
| nv_req_addr | output | 13 | Storage byte address |
| nv_req_wdata | output | 8 | Storage write byte |
| nv_req_ready | input | 1 | Storage accepts the request |
| nv_rsp_valid | input | 1 | Storage read data valid |
| nv_rsp_data | input | 8 | Storage read byte |
| cpu_rst_n | output | 1 | Processor reset, active low |
| programmed | output | 1 | Image loaded |

## Verification
The hardest situation to reach is a read response from storage that was still in flight when the mode changed. It can only occur when the mode changes while a storage-mode read is outstanding, and it must not corrupt the next load. The bench tags every accepted storage request with a load epoch and discards responses whose epoch is stale. It then aborts a storage-mode load midway and starts a host load straight afterwards. The full-FIFO drop is reached by holding storage ready low in mirror mode, so that no byte can leave the FIFO, and then pushing 33 bytes.

// File: rtl/boot_pkg.sv
`timescale 1ns/1ps
// Shared types for the boot loader controller.
// Mode encodings are fixed by the external control register and must not move.
package boot_pkg;

    typedef enum logic [1:0] {
        MODE_HALT   = 2'b00,
        MODE_MIRROR = 2'b01,
        MODE_HOST   = 2'b10,
        MODE_STORE  = 2'b11
    } boot_mode_e;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_HOST,
        ST_NV_REQ,
        ST_NV_WAIT,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/boot_fifo.sv
`timescale 1ns/1ps
// Input byte FIFO for host packets.
// Drops pushes while full and ignores pops while empty. A flush empties it in one cycle.
// Assumes DEPTH >= 2.
module boot_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              do_push, do_pop;

    assign empty_o = (count == '0);
    assign full_o  = (count == FULL_CNT);
    assign do_push = push_i && !full_o && !flush_i;
    assign do_pop  = pop_i && !empty_o && !flush_i;
    assign dout_o  = mem[rd_ptr];

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din_i;
    end

    // Advance the pointers and the occupancy, or clear them on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R7
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !flush_i) |=> full_o); // R7

endmodule

// File: rtl/boot_mode_track.sv
`timescale 1ns/1ps
// Registers the boot mode that the current load runs under and flags any change.
// Out of reset the registered mode is halt, so a non-halt mode starts a load at once.
module boot_mode_track
    import boot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    output boot_mode_e mode_new_o,
    output boot_mode_e mode_q_o,
    output logic       restart_o
);
    assign mode_new_o = boot_mode_e'(mode_i);
    assign restart_o  = (mode_new_o != mode_q_o);

    // Capture the mode that is in force for the running load.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q_o <= MODE_HALT;
        else        mode_q_o <= mode_new_o;
    end

endmodule

// File: rtl/boot_seq.sv
`timescale 1ns/1ps
// Load sequencer: walks program memory addresses from 0 to the top and fetches each byte
// from the host FIFO or from storage. It mirrors host bytes into storage in mirror mode
// and signals completion.
// Assumes at most one storage read outstanding, with its response arriving after acceptance.
module boot_seq
    import boot_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  boot_mode_e        new_mode_i,
    input  boot_mode_e        active_mode_i,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    output logic              fifo_pop_o,
    output logic              host_phase_o,
    output logic              pm_we_o,
    output logic [ADDR_W-1:0] pm_addr_o,
    output logic [DATA_W-1:0] pm_wdata_o,
    output logic              nv_req_valid_o,
    output logic              nv_req_write_o,
    output logic [ADDR_W-1:0] nv_req_addr_o,
    output logic [DATA_W-1:0] nv_req_wdata_o,
    input  logic              nv_req_ready_i,
    input  logic              nv_rsp_valid_i,
    input  logic [DATA_W-1:0] nv_rsp_data_i,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    seq_state_e        state, state_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic              at_top;

    // Pick the first state of a load for a given mode.
    function automatic seq_state_e first_state(boot_mode_e m);
        case (m)
            MODE_MIRROR, MODE_HOST: first_state = ST_HOST;
            MODE_STORE:             first_state = ST_NV_REQ;
            default:                first_state = ST_HALT;
        endcase
    endfunction

    assign at_top         = (addr_q == TOP_ADDR);
    assign pm_addr_o      = addr_q;
    assign nv_req_addr_o  = addr_q;
    assign nv_req_wdata_o = fifo_data_i;
    assign pm_wdata_o     = (state == ST_NV_WAIT) ? nv_rsp_data_i : fifo_data_i;
    assign host_phase_o   = (state == ST_HOST);
    assign done_o         = (state == ST_DONE);

    // Decide the strobes for this cycle and the next state; a restart silences everything.
    always_comb begin
        fifo_pop_o     = 1'b0;
        pm_we_o        = 1'b0;
        nv_req_valid_o = 1'b0;
        nv_req_write_o = 1'b0;
        state_nxt      = state;
        if (!restart_i) begin
            case (state)
                ST_HOST: begin
                    if (!fifo_empty_i) begin
                        if (active_mode_i == MODE_MIRROR) begin
                            nv_req_valid_o = 1'b1;
                            nv_req_write_o = 1'b1;
                            fifo_pop_o     = nv_req_ready_i;
                            pm_we_o        = nv_req_ready_i;
                        end else begin
                            fifo_pop_o = 1'b1;
                            pm_we_o    = 1'b1;
                        end
                    end
                    if (pm_we_o && at_top) state_nxt = ST_DONE;
                end
                ST_NV_REQ: begin
                    nv_req_valid_o = 1'b1;
                    if (nv_req_ready_i) state_nxt = ST_NV_WAIT;
                end
                ST_NV_WAIT: begin
                    if (nv_rsp_valid_i) begin
                        pm_we_o   = 1'b1;
                        state_nxt = at_top ? ST_DONE : ST_NV_REQ;
                    end
                end
                default: state_nxt = state;
            endcase
        end
    end

    // Hold the state and the byte address; restart from address 0 on any mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_HALT;
            addr_q <= '0;
        end else if (restart_i) begin
            state  <= first_state(new_mode_i);
            addr_q <= '0;
        end else begin
            state <= state_nxt;
            if (pm_we_o) addr_q <= addr_q + 1'b1;
        end
    end

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode_i == MODE_HALT) |-> (!pm_we_o && !nv_req_valid_o && !fifo_pop_o)); // R1
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pm_we_o |=> (addr_q == $past(addr_q) + 1'b1)); // R2
    AST_MIRROR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_we_o && active_mode_i == MODE_MIRROR) |->
        (nv_req_valid_o && nv_req_ready_i && nv_req_write_o && nv_req_addr_o == pm_addr_o)); // R3
    AST_HOST_NO_NV: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode_i == MODE_HOST) |-> !nv_req_valid_o); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req_valid_o && !nv_req_ready_i && !restart_i) |=>
        (restart_i || (nv_req_valid_o && $stable(nv_req_addr_o)))); // R5
    AST_DONE_AFTER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(pm_we_o) && $past(pm_addr_o) == TOP_ADDR)); // R6
    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!done_o && addr_q == '0)); // R8

endmodule

// File: rtl/boot_loader_ctrl.sv
`timescale 1ns/1ps
// Boot loader controller top: fills program memory from the host FIFO or from storage,
// according to the boot mode, then releases the processor.
// Assumes the host sends a packet only while the FIFO reports empty.
module boot_loader_ctrl
    import boot_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int PKT_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        boot_mode,
    input  logic              host_push,
    input  logic [DATA_W-1:0] host_data,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              pm_we,
    output logic [ADDR_W-1:0] pm_addr,
    output logic [DATA_W-1:0] pm_wdata,
    output logic              nv_req_valid,
    output logic              nv_req_write,
    output logic [ADDR_W-1:0] nv_req_addr,
    output logic [DATA_W-1:0] nv_req_wdata,
    input  logic              nv_req_ready,
    input  logic              nv_rsp_valid,
    input  logic [DATA_W-1:0] nv_rsp_data,
    output logic              cpu_rst_n,
    output logic              programmed
);
    boot_mode_e        mode_new, mode_q;
    logic              restart, host_phase, fifo_pop, push_ok, done;
    logic [DATA_W-1:0] fifo_data;

    // Host bytes are only taken while a host load is in progress.
    assign push_ok    = host_push && host_phase && !restart;
    assign cpu_rst_n  = done;
    assign programmed = done;

    boot_mode_track u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (boot_mode),
        .mode_new_o (mode_new),
        .mode_q_o   (mode_q),
        .restart_o  (restart)
    );

    boot_fifo #(.DATA_W(DATA_W), .DEPTH(PKT_BYTES)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (restart),
        .push_i  (push_ok),
        .din_i   (host_data),
        .pop_i   (fifo_pop),
        .dout_o  (fifo_data),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    boot_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .restart_i      (restart),
        .new_mode_i     (mode_new),
        .active_mode_i  (mode_q),
        .fifo_empty_i   (fifo_empty),
        .fifo_data_i    (fifo_data),
        .fifo_pop_o     (fifo_pop),
        .host_phase_o   (host_phase),
        .pm_we_o        (pm_we),
        .pm_addr_o      (pm_addr),
        .pm_wdata_o     (pm_wdata),
        .nv_req_valid_o (nv_req_valid),
        .nv_req_write_o (nv_req_write),
        .nv_req_addr_o  (nv_req_addr),
        .nv_req_wdata_o (nv_req_wdata),
        .nv_req_ready_i (nv_req_ready),
        .nv_rsp_valid_i (nv_rsp_valid),
        .nv_rsp_data_i  (nv_rsp_data),
        .done_o         (done)
    );

    AST_RST_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !$past(restart)) |=> !cpu_rst_n); // R6

endmodule

// File: tb/test_boot_loader_ctrl.sv
`timescale 1ns/1ps
module test_boot_loader_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int IMG = 8192;
    localparam int PKT = 32;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [1:0] boot_mode = 2'b00;
    logic       host_push = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       nv_req_ready = 1'b0, nv_rsp_valid = 1'b0;
    logic [7:0] nv_rsp_data = 8'h00;
    logic       fifo_empty, fifo_full, pm_we, nv_req_valid, nv_req_write, cpu_rst_n, programmed;
    logic [12:0] pm_addr, nv_req_addr;
    logic [7:0]  pm_wdata, nv_req_wdata;

    int n_checks = 0, n_fail = 0;
    int cur_mode = 0, exp_addr = 0, host_idx = 0, epoch = 0, salt = 0;
    bit stall_nv = 1'b0, prev_prog = 1'b0, prev_top = 1'b0, finished = 1'b0;

    boot_loader_ctrl i_boot_loader_ctrl (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .host_push(host_push),
        .host_data(host_data), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .nv_req_valid(nv_req_valid), .nv_req_write(nv_req_write), .nv_req_addr(nv_req_addr),
        .nv_req_wdata(nv_req_wdata), .nv_req_ready(nv_req_ready), .nv_rsp_valid(nv_rsp_valid),
        .nv_rsp_data(nv_rsp_data), .cpu_rst_n(cpu_rst_n), .programmed(programmed)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] nv_byte(int a);
        return 8'((a * 37) ^ (a >> 5) ^ 8'h5A);
    endfunction

    function automatic logic [7:0] host_byte(int i, int s);
        return 8'((i * 113) + (s * 29) + (i >> 8));
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Mode change: the restart is visible one cycle later (R8).
    task automatic set_mode(int m);
        boot_mode = 2'(m);
        cur_mode  = m;
        exp_addr  = 0;
        host_idx  = 0;
        salt      = int'($urandom % 256);
        epoch++;
        tick();
        check(!programmed, "R8", "programmed after mode change", programmed, 0);
        check(!cpu_rst_n, "R8", "cpu_rst_n after mode change", cpu_rst_n, 0);
        check(fifo_empty, "R8", "fifo flushed after mode change", fifo_empty, 1);
    endtask

    task automatic push_packets(int npk);
        for (int p = 0; p < npk; p++) begin
            while (!fifo_empty) tick();
            for (int i = 0; i < PKT; i++) begin
                host_push = 1'b1;
                host_data = host_byte(host_idx, salt);
                host_idx++;
                tick();
            end
            host_push = 1'b0;
        end
    endtask

    task automatic wait_done(string req);
        while (!programmed) tick();
        check(cpu_rst_n, req, "cpu_rst_n after load", cpu_rst_n, 1);
        check(exp_addr == IMG, req, "bytes written in load", exp_addr, IMG);
    endtask

    // Storage model: random ready, one read in flight, stale responses dropped by epoch.
    always begin : nv_model
        bit acc;
        int acc_addr, acc_epoch;
        static bit pend = 1'b0;
        static int pend_cnt = 0, pend_addr = 0, pend_epoch = 0;
        @(negedge clk);
        acc       = nv_req_valid && nv_req_ready && !nv_req_write;
        acc_addr  = int'(nv_req_addr);
        acc_epoch = epoch;
        @(posedge clk);
        #1;
        nv_rsp_valid = 1'b0;
        if (pend) begin
            if (pend_epoch != epoch) pend = 1'b0;
            else if (pend_cnt == 0) begin
                nv_rsp_valid = 1'b1;
                nv_rsp_data  = nv_byte(pend_addr);
                pend = 1'b0;
            end else pend_cnt--;
        end
        if (acc) begin
            pend = 1'b1;
            pend_cnt = int'($urandom % 3);
            pend_addr = acc_addr;
            pend_epoch = acc_epoch;
        end
        nv_req_ready = stall_nv ? 1'b0 : 1'($urandom % 2);
    end

    // Scoreboard sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pm_we) begin
                logic [7:0] exp_b;
                exp_b = (cur_mode == 3) ? nv_byte(exp_addr) : host_byte(exp_addr, salt);
                check(cur_mode != 0, "R1", "write in halt mode", 1, 0);
                check(int'(pm_addr) == exp_addr, "R2", "pm_addr", int'(pm_addr), exp_addr);
                check(pm_wdata == exp_b, (cur_mode == 3) ? "R5" : "R2", "pm_wdata",
                      int'(pm_wdata), int'(exp_b));
                if (cur_mode == 1)
                    check(nv_req_valid && nv_req_ready && nv_req_write &&
                          nv_req_addr == pm_addr && nv_req_wdata == pm_wdata,
                          "R3", "mirror write paired", int'(nv_req_addr), int'(pm_addr));
                exp_addr++;
            end
            if (cur_mode == 2) check(!nv_req_valid, "R4", "storage request in host mode", nv_req_valid, 0);
            if (cur_mode == 0) check(!nv_req_valid, "R1", "storage request in halt mode", nv_req_valid, 0);
            if (prev_top) check(programmed && cpu_rst_n, "R6", "release after top address", programmed, 1);
            if (!programmed) check(!cpu_rst_n, "R6", "cpu_rst_n before programmed", cpu_rst_n, 0);
            prev_top  = pm_we && (pm_addr == 13'h1FFF);
            prev_prog = programmed;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = int'($urandom(32'd20141106));
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        check(!cpu_rst_n, "R1", "cpu_rst_n out of reset", cpu_rst_n, 0);
        check(!programmed, "R1", "programmed out of reset", programmed, 0);
        check(fifo_empty, "R7", "fifo_empty out of reset", fifo_empty, 1);
        check(!fifo_full, "R7", "fifo_full out of reset", fifo_full, 0);

        // Halt mode: host bytes discarded.
        for (int i = 0; i < 10; i++) begin
            host_push = 1'b1;
            host_data = 8'(i);
            tick();
        end
        host_push = 1'b0;
        tick();
        check(fifo_empty, "R1", "fifo after halt pushes", fifo_empty, 1);
        check(!cpu_rst_n, "R1", "cpu held in halt", cpu_rst_n, 0);

        // Host-only load.
        set_mode(2);
        push_packets(IMG / PKT);
        wait_done("R4");
        for (int i = 0; i < 5; i++) begin
            host_push = 1'b1;
            host_data = 8'hEE;
            tick();
        end
        host_push = 1'b0;
        tick();
        check(fifo_empty, "R6", "bytes after completion dropped", fifo_empty, 1);
        check(programmed, "R6", "programmed holds", programmed, 1);

        // Mirror load with overflow attempt on the first packet.
        stall_nv = 1'b1;
        tick();
        tick();
        set_mode(1);
        for (int i = 0; i < PKT; i++) begin
            host_push = 1'b1;
            host_data = host_byte(host_idx, salt);
            host_idx++;
            tick();
        end
        host_push = 1'b1;
        host_data = ~host_byte(PKT, salt);
        tick();
        host_push = 1'b0;
        tick();
        check(fifo_full, "R7", "fifo_full with 32 bytes", fifo_full, 1);
        check(!fifo_empty, "R7", "fifo_empty with 32 bytes", fifo_empty, 0);
        check(exp_addr == 0, "R3", "no write while storage stalls", exp_addr, 0);
        stall_nv = 1'b0;
        push_packets(IMG / PKT - 1);
        wait_done("R3");

        // Abort a host load into a storage load.
        set_mode(2);
        push_packets(3);
        repeat (5) tick();
        set_mode(3);
        for (int i = 0; i < 8; i++) begin
            host_push = 1'b1;
            host_data = 8'hA5;
            tick();
            check(fifo_empty, "R5", "host byte in storage mode", fifo_empty, 1);
        end
        host_push = 1'b0;
        wait_done("R5");

        // Abort mirror load into halt.
        set_mode(1);
        push_packets(2);
        set_mode(0);
        repeat (10) tick();
        check(!programmed && !cpu_rst_n, "R1", "halt after abort", programmed, 0);

        // Abort a storage load with reads in flight, then a host load.
        set_mode(3);
        repeat (300) tick();
        check(!programmed, "R6", "not programmed mid storage load", programmed, 0);
        set_mode(2);
        push_packets(2);
        while (!fifo_empty) tick();
        repeat (3) tick();
        check(exp_addr == 2 * PKT, "R8", "bytes after restart", exp_addr, 2 * PKT);
        set_mode(0);
        tick();
        report();
    end
endmodule